// File: doc/BRIEF.md
# GPIO Port Interrupt Sense Unit

This block watches the input pads of an eight-pin general-purpose I/O port and raises one interrupt line when a configured event occurs on a pin that software has enabled. Each pin can be set to edge or level sensing. In edge mode a pin can trigger on one chosen edge or on both edges. A polarity setting picks rising edges or high levels, or falling edges or low levels. A per-pin enable decides whether the pin can reach the interrupt line.

The pads are synchronized before any detection takes place. Edge events are held in a sticky raw status until software writes a 1 to the matching bit at the clear offset. In level mode the raw status simply follows the synchronized pin level. The masked status is the raw status gated by the per-pin enables, and the interrupt line is high whenever any masked bit is set. A parameter marks which pin positions are bonded to pads. Unbonded positions ignore writes, never report events and read as 0.

Register offsets on the 3-bit address: 0 sense, 1 both-edges, 2 polarity, 3 enable, 4 raw status (read-only), 5 masked status (read-only), 6 clear (write-1, reads 0), 7 unused (reads 0). Read data is combinational from the address. A write takes effect at the rising clock edge on which `wr_en` is high.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset every configuration register, the raw status and the masked status read 0, and `irq` is 0.
- R2: Offsets 0 to 3 read back the last value written, ANDed with the bonded-pin parameter. Offsets 6 and 7 read 0. Writes to offsets 4, 5 and 7 have no effect.
- R3: A pad change first sampled at clock edge k sets an edge-mode raw bit that is visible after edge k+2. A level-mode raw bit follows the pad after edge k+1.
- R4: In edge mode (sense bit 0) with both-edges bit 0, polarity bit 1 latches only rising edges and polarity bit 0 latches only falling edges.
- R5: With both-edges bit 1 in edge mode, rising and falling edges both latch, whatever the polarity bit is.
- R6: In level mode (sense bit 1) the raw bit equals the synchronized pin when polarity is 1, and its inverse when polarity is 0. Writing clear does not drop it while the level persists.
- R7: A latched edge bit stays set until a 1 is written to the same bit position at offset 6, which clears it at that write's clock edge.
- R8: When an edge event and a clear of the same bit take effect at the same clock edge, the bit stays set.
- R9: The masked status equals raw status AND enable. `irq` is 1 exactly when the masked status is nonzero.
- R10: Writing the sense, both-edges or polarity registers never latches an edge event by itself.
- R11: Pin positions marked unbonded in the parameter (bit 4 by default) never show raw or masked status and never drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_in | input | NPINS | Asynchronous pad levels |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for `addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check four things on every cycle. A detected edge is present in the sticky status on the following cycle, even when a clear hits the same bit. A latched bit never drops without a clear. A clear with no competing event always empties the bit. Masked status never shows a disabled or unbonded pin. The bench's scenarios are needed for the rest. They cover the two-stage synchronizer delay, the choice of polarity against the both-edges override, a level that cannot be cleared while it persists, and the absence of events after reconfiguration. A behavioural model tracks these on every clock while random pad and register traffic runs.

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int NPINS = 8,
  parameter logic [NPINS-1:0] CONN = NPINS'(8'hEF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  output logic             irq
);
  localparam logic [2:0] A_SENSE = 3'd0;
  localparam logic [2:0] A_BOTH  = 3'd1;
  localparam logic [2:0] A_POL   = 3'd2;
  localparam logic [2:0] A_EN    = 3'd3;
  localparam logic [2:0] A_RAW   = 3'd4;
  localparam logic [2:0] A_MSK   = 3'd5;
  localparam logic [2:0] A_CLR   = 3'd6;

  logic [NPINS-1:0] s1, s2, prev;
  logic [NPINS-1:0] sense, both, pol, mask_r;
  logic [NPINS-1:0] raw_edge, raw, msk, lvl, ev, clr_w, rise, fall;

  assign rise  = s2 & ~prev;
  assign fall  = ~s2 & prev;
  assign ev    = CONN & ~sense & ((both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall));
  assign lvl   = CONN & sense & ~(s2 ^ pol);
  assign clr_w = (wr_en && addr == A_CLR) ? (wdata & CONN) : '0;
  assign raw   = (raw_edge & ~sense) | lvl;
  assign msk   = raw & mask_r;
  assign irq   = |msk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
      sense <= '0; both <= '0; pol <= '0; mask_r <= '0;
      raw_edge <= '0;
    end else begin
      s1   <= pad_in;
      s2   <= s1;
      prev <= s2;
      raw_edge <= (raw_edge & ~clr_w) | ev;
      if (wr_en) begin
        case (addr)
          A_SENSE: sense  <= wdata & CONN;
          A_BOTH:  both   <= wdata & CONN;
          A_POL:   pol    <= wdata & CONN;
          A_EN:    mask_r <= wdata & CONN;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_SENSE: rdata = sense;
      A_BOTH:  rdata = both;
      A_POL:   rdata = pol;
      A_EN:    rdata = mask_r;
      A_RAW:   rdata = raw;
      A_MSK:   rdata = msk;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int NPINS = 8,
  parameter logic [NPINS-1:0] CONN = NPINS'(8'hEF)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] raw_edge,
  input logic [NPINS-1:0] ev,
  input logic [NPINS-1:0] clr_w,
  input logic [NPINS-1:0] msk,
  input logic [NPINS-1:0] mask_r,
  input logic [NPINS-1:0] raw
);
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_edge & $past(ev)) == $past(ev))); // R8

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~raw_edge & $past(raw_edge & ~clr_w)) == '0)); // R7

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_edge & $past(clr_w & ~ev)) == '0)); // R7

  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (msk & ~mask_r) == '0); // R9

  AST_UNBONDED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw | msk) & ~CONN) == '0); // R11
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPINS(NPINS), .CONN(CONN)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_edge(raw_edge), .ev(ev),
  .clr_w(clr_w), .msk(msk), .mask_r(mask_r), .raw(raw)
);

// File: tb/gpio_irq_sense_test.sv
module gpio_irq_sense_test;
  localparam logic [7:0] CONN = 8'hEF;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq;
  logic [7:0] pad_in = '0, wdata = '0, rdata;
  logic [2:0] addr = '0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  gpio_irq_sense uut (.clk(clk), .rst_n(rst_n), .pad_in(pad_in), .wr_en(wr_en),
                      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  logic [7:0] m_sense, m_both, m_pol, m_en, m_rawe;
  logic [7:0] hist[$];

  function automatic logic [7:0] m_raw();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = m_sense[i] ? (m_pol[i] ? hist[1][i] : !hist[1][i]) : m_rawe[i];
    return r & CONN;
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_sense;
      3'd1: return m_both;
      3'd2: return m_pol;
      3'd3: return m_en;
      3'd4: return m_raw();
      3'd5: return m_raw() & m_en;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sense = 0; m_both = 0; m_pol = 0; m_en = 0; m_rawe = 0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      logic [7:0] ev, clr;
      for (int i = 0; i < 8; i++) begin
        logic r, f;
        r = hist[1][i] && !hist[2][i];
        f = !hist[1][i] && hist[2][i];
        ev[i] = !m_sense[i] && (m_both[i] ? (r || f) : (m_pol[i] ? r : f));
      end
      clr = (wr_en && addr == 3'd6) ? wdata : 8'h00;
      m_rawe = ((m_rawe & ~clr) | ev) & CONN;
      if (wr_en) begin
        if (addr == 3'd0) m_sense = wdata & CONN;
        if (addr == 3'd1) m_both  = wdata & CONN;
        if (addr == 3'd2) m_pol   = wdata & CONN;
        if (addr == 3'd3) m_en    = wdata & CONN;
      end
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd4: return "R4";
      3'd5: return "R9";
      3'd6: return "R7";
      default: return "R2";
    endcase
  endfunction

  always @(negedge clk) if (rst_n && hist.size() == 3) begin
    check("R9 irq", {7'd0, irq}, {7'd0, (m_raw() & m_en) != 0});
    check(tag_of(addr), rdata, m_read(addr));
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic peek(string tag, logic [2:0] a, logic [7:0] exp);
    addr = a; #6;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    for (int a = 0; a < 8; a++) peek("R1 reset", 3'(a), 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 readback masked by bonded pins, read-only offsets ignore writes
    for (int a = 0; a < 4; a++) begin wr(3'(a), 8'hFF); peek("R2 rw", 3'(a), CONN); end
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    peek("R2 ro raw", 3'd4, 8'h00);
    peek("R2 off7", 3'd7, 8'h00);
    for (int a = 0; a < 4; a++) wr(3'(a), 8'h00);

    // R3/R4 pin 2 rising edge with enable on pin 2 only
    wr(3'd2, 8'h04); wr(3'd3, 8'h04);
    pad_in[2] = 1'b1;
    step(); peek("R3 k+1", 3'd4, 8'h00);
    step(); peek("R3 k+2 pre", 3'd4, 8'h00);
    step(); peek("R3 edge visible", 3'd4, 8'h04);
    check("R9 irq on", {7'd0, irq}, 8'h01);
    wr(3'd6, 8'h04); peek("R7 cleared", 3'd4, 8'h00);
    pad_in[2] = 1'b0; step(4);
    peek("R4 falling ignored", 3'd4, 8'h00);

    // R4 falling polarity on pin 0
    pad_in[0] = 1'b1; step(4);
    peek("R4 rise ignored pol0", 3'd4, 8'h00);
    pad_in[0] = 1'b0; step(4);
    peek("R4 fall latched", 3'd4, 8'h01);
    peek("R9 masked hides pin0", 3'd5, 8'h00);
    wr(3'd6, 8'hFF);

    // R5 both edges overrides polarity
    wr(3'd1, 8'h08); wr(3'd2, 8'h08);
    pad_in[3] = 1'b1; step(4); peek("R5 rise", 3'd4, 8'h08);
    wr(3'd6, 8'h08);
    pad_in[3] = 1'b0; step(4); peek("R5 fall", 3'd4, 8'h08);
    wr(3'd6, 8'h08); wr(3'd1, 8'h00); wr(3'd2, 8'h00);

    // R6 level mode
    wr(3'd0, 8'h01); wr(3'd2, 8'h01);
    pad_in[0] = 1'b1;
    step(); peek("R6 k+1", 3'd4, 8'h00);
    step(); peek("R6 level high", 3'd4, 8'h01);
    wr(3'd6, 8'h01); peek("R6 clear no effect", 3'd4, 8'h01);
    pad_in[0] = 1'b0; step(3); peek("R6 level gone", 3'd4, 8'h00);
    wr(3'd2, 8'h00); peek("R6 low level", 3'd4, 8'h01);
    wr(3'd0, 8'h00); wr(3'd6, 8'hFF);

    // R8 event and clear at the same edge
    wr(3'd2, 8'h02);
    pad_in[1] = 1'b1;
    step(2);
    wr(3'd6, 8'h02);
    peek("R8 event wins", 3'd4, 8'h02);
    wr(3'd6, 8'h02); peek("R7 later clear", 3'd4, 8'h00);

    // R10 reconfiguration with pin 1 steady high
    wr(3'd2, 8'h00); wr(3'd1, 8'h02); wr(3'd2, 8'h02); wr(3'd1, 8'h00);
    step(3); peek("R10 no event", 3'd4, 8'h00);

    // R11 unbonded pin 4
    wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
    pad_in[4] = 1'b1; step(4); peek("R11 raw", 3'd4, 8'h00);
    pad_in[4] = 1'b0; step(4); peek("R11 masked", 3'd5, 8'h00);
    check("R11 irq", {7'd0, irq}, 8'h00);

    for (int n = 0; n < 600; n++) begin
      pad_in = 8'($urandom);
      if ($urandom_range(3) == 0) wr(3'($urandom), 8'($urandom));
      else begin addr = 3'($urandom); step(); end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule